// File: doc/BRIEF.md
# Cache Tag Store with Qualified Hit

This block holds the tag side of a secondary cache. An address selects one line entry. Each entry stores a tag word and three status bits. The block compares the stored tag at the applied address with an incoming tag and raises a hit flag. In the built-in status mode, that flag only rises when the entry is valid.

Reads and the compare are purely combinational from address and data. Tag writes and status writes are taken on the rising clock edge, each under its own enable. A clocked, active-low clear wipes the status bits of every entry in one edge, which invalidates the whole cache. The tags themselves are left in place.

Two selects must both be active for writes to land and for any output to drive, so several instances can share a bus to extend depth. A mode input turns the status bits into plain user storage that no longer touches the hit or ready logic. An active-low ready output for the processor is formed from the hit, the status bits and three external controls.

Top module: `tag_match_store`

## Requirements
- R1: With `clr_n` low at a rising edge, every entry's status bits (bit 0 valid, bit 1 dirty, bit 2 write-through) become 0, and no stored tag changes.
- R2: With the block selected and `tag_we` high at a rising edge, the entry at `addr` takes `tag_in`; its status bits are unchanged.
- R3: With the block selected, `clr_n` high and `stat_we` high at a rising edge, the entry at `addr` takes `stat_in`; its tag is unchanged.
- R4: When `clr_n` is low and a status write is requested in the same edge, the clear wins and the addressed status reads 0.
- R5: `tag_out` and `stat_out` show the stored entry at `addr` combinationally when their drive flag is high, and read 0 when it is low. `tag_drv` is selected AND `tag_oe`, and `stat_drv` is selected AND `stat_oe`.
- R6: With `user_mode` low, `hit` is 1 exactly when the block is selected, the stored tag equals `tag_in`, and the entry's valid bit is 1.
- R7: With `user_mode` high, `hit` ignores the valid bit, and the write-through bit has no effect on `rdy_n`.
- R8: The block is selected only when `sel_a_n` is 0 and `sel_b` is 1. When it is not selected, writes have no effect, `hit` is 0 and every drive flag is 0.
- R9: `rdy_n` is 1 whenever `rdy_force` is 1. Otherwise it is 0 when `rdy_ext_n` is 0, or when `hit` is 1 and either `is_write` is 0 or the entry's write-through bit is 0 (defined mode only). `rdy_drv` is selected AND `rdy_oe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for writes and clear |
| clr_n | input | 1 | Clocked active-low clear of all status bits |
| sel_a_n | input | 1 | Active-low select |
| sel_b | input | 1 | Active-high select |
| addr | input | ADDR_W | Line index |
| tag_in | input | TAG_W | Tag to write and to compare |
| stat_in | input | 3 | Status to write: bit 0 valid, bit 1 dirty, bit 2 write-through |
| tag_we | input | 1 | Tag write enable |
| stat_we | input | 1 | Status write enable |
| tag_oe | input | 1 | Tag output enable |
| stat_oe | input | 1 | Status output enable |
| rdy_oe | input | 1 | Ready output enable |
| user_mode | input | 1 | 0: built-in status meaning, 1: generic status |
| rdy_force | input | 1 | Forces `rdy_n` inactive |
| rdy_ext_n | input | 1 | Extra active-low ready input |
| is_write | input | 1 | 1 for a processor write, 0 for a read |
| tag_out | output | TAG_W | Stored tag at `addr` |
| tag_drv | output | 1 | Tag output drive flag |
| stat_out | output | 3 | Stored status at `addr` |
| stat_drv | output | 1 | Status output drive flag |
| hit | output | 1 | Qualified tag match |
| rdy_n | output | 1 | Active-low burst ready |
| rdy_drv | output | 1 | Ready output drive flag |

## Verification
The bench builds the block with ADDR_W of 8 and TAG_W of 12, giving 256 entries. That depth is small enough to fill every entry with a known tag before random traffic starts, so every compare and read has a known expected value. The narrow address makes random accesses revisit lines often, which brings reads after writes and after clears within reach. The full tag width keeps near-miss compares meaningful, because random tags rarely collide and directed equal tags exercise the hit path.

// File: rtl/tag_match_store.sv
module tag_match_store #(
  parameter int ADDR_W = 8,
  parameter int TAG_W  = 12
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TAG_W-1:0]  tag_in,
  input  logic [2:0]        stat_in,
  input  logic              tag_we,
  input  logic              stat_we,
  input  logic              tag_oe,
  input  logic              stat_oe,
  input  logic              rdy_oe,
  input  logic              user_mode,
  input  logic              rdy_force,
  input  logic              rdy_ext_n,
  input  logic              is_write,
  output logic [TAG_W-1:0]  tag_out,
  output logic              tag_drv,
  output logic [2:0]        stat_out,
  output logic              stat_drv,
  output logic              hit,
  output logic              rdy_n,
  output logic              rdy_drv
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [DEPTH-1:0] vld_q, dty_q, wt_q;
  logic             sel;
  logic [TAG_W-1:0] tag_rd;
  logic [2:0]       stat_rd;
  logic             wt_eff;

  assign sel     = !sel_a_n && sel_b;
  assign tag_rd  = tag_q[addr];
  assign stat_rd = {wt_q[addr], dty_q[addr], vld_q[addr]};

  always_ff @(posedge clk)
    if (sel && tag_we) tag_q[addr] <= tag_in;

  always_ff @(posedge clk) begin
    if (!clr_n) begin
      vld_q <= '0;
      dty_q <= '0;
      wt_q  <= '0;
    end else if (sel && stat_we) begin
      vld_q[addr] <= stat_in[0];
      dty_q[addr] <= stat_in[1];
      wt_q[addr]  <= stat_in[2];
    end
  end

  assign hit      = sel && (tag_rd == tag_in) && (user_mode || stat_rd[0]);
  assign wt_eff   = !user_mode && stat_rd[2];
  assign rdy_n    = rdy_force || !(!rdy_ext_n || (hit && (!is_write || !wt_eff)));

  assign tag_drv  = sel && tag_oe;
  assign stat_drv = sel && stat_oe;
  assign rdy_drv  = sel && rdy_oe;
  assign tag_out  = tag_drv  ? tag_rd  : '0;
  assign stat_out = stat_drv ? stat_rd : '0;

  // R1
  clear_wipes_chk: assert property (@(posedge clk)
    !clr_n |=> stat_rd == 3'b000);

  // R2
  tag_write_lands_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (sel && tag_we) ##1 $stable(addr) |-> tag_rd == $past(tag_in));

  // R8
  hit_needs_sel_chk: assert property (@(posedge clk) disable iff (!clr_n)
    hit |-> (!sel_a_n && sel_b));

  // R9
  force_wins_chk: assert property (@(posedge clk) disable iff (!clr_n)
    rdy_force |-> rdy_n);
endmodule

// File: tb/sim_tag_match_store.sv
module sim_tag_match_store;
  localparam int CLK_NS = 10;
  localparam int AW = 8;
  localparam int TW = 12;
  localparam int N  = 1 << AW;

  logic clk = 0, clr_n = 1, sel_a_n = 1, sel_b = 0;
  logic [AW-1:0] addr = '0;
  logic [TW-1:0] tag_in = '0;
  logic [2:0] stat_in = '0;
  logic tag_we = 0, stat_we = 0, tag_oe = 0, stat_oe = 0, rdy_oe = 0;
  logic user_mode = 0, rdy_force = 0, rdy_ext_n = 1, is_write = 0;
  logic [TW-1:0] tag_out;
  logic [2:0] stat_out;
  logic tag_drv, stat_drv, hit, rdy_n, rdy_drv;

  logic [TW-1:0] mtag [N];
  logic [2:0]    mstat [N];
  int vecs = 0, bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  tag_match_store #(.ADDR_W(AW), .TAG_W(TW)) u0 (.*);

  function automatic logic selected();
    return !sel_a_n && sel_b;
  endfunction
  function automatic logic exp_hit();
    return selected() && mtag[addr] == tag_in && (user_mode || mstat[addr][0]);
  endfunction
  function automatic logic exp_rdy_n();
    if (rdy_force) return 1'b1;
    return !(!rdy_ext_n || (exp_hit() && (!is_write || user_mode || !mstat[addr][2])));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic check_all();
    #1;
    chk("R5 tag_out", 32'(tag_out), (selected() && tag_oe) ? 32'(mtag[addr]) : 0);
    chk("R5 stat_out", 32'(stat_out), (selected() && stat_oe) ? 32'(mstat[addr]) : 0);
    chk("R8 drive flags", {tag_drv, stat_drv, rdy_drv},
        {selected() && tag_oe, selected() && stat_oe, selected() && rdy_oe});
    chk(user_mode ? "R7 hit" : "R6 hit", 32'(hit), 32'(exp_hit()));
    chk("R9 rdy_n", 32'(rdy_n), 32'(exp_rdy_n()));
  endtask

  task automatic clock_in();
    @(posedge clk);
    if (!clr_n) for (int i = 0; i < N; i++) mstat[i] = 3'b000;
    else if (selected() && stat_we) mstat[addr] = stat_in;
    if (selected() && tag_we) mtag[addr] = tag_in;
    @(negedge clk);
  endtask

  task automatic idle();
    tag_we = 0; stat_we = 0; clr_n = 1;
  endtask

  initial begin
    #(CLK_NS * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    // R1: clear at start gives all-zero status
    clr_n = 0;
    clock_in();
    idle();
    sel_a_n = 0; sel_b = 1; stat_oe = 1; tag_oe = 1;
    for (int i = 0; i < 8; i++) begin
      addr = AW'(i * 37); #1;
      chk("R1 reset state", 32'(stat_out), 0);
      chk("R6 invalid no hit", 32'(hit), 0);
    end
    // fill tags (R2)
    for (int i = 0; i < N; i++) begin
      addr = AW'(i); tag_in = TW'($urandom); tag_we = 1;
      clock_in();
    end
    idle();
    // R2: tag write leaves status alone; R3 status write leaves tag alone
    addr = 8'h15; stat_in = 3'b101; stat_we = 1; clock_in(); idle();
    tag_in = 12'hABC; tag_we = 1; clock_in(); idle(); #1;
    chk("R2 tag written", 32'(tag_out), 32'h0ABC);
    chk("R2 status kept", 32'(stat_out), 32'h5);
    stat_in = 3'b010; stat_we = 1; clock_in(); idle(); #1;
    chk("R3 status written", 32'(stat_out), 32'h2);
    chk("R3 tag kept", 32'(tag_out), 32'h0ABC);
    // R4: clear beats same-edge status write
    stat_in = 3'b111; stat_we = 1; clr_n = 0; clock_in(); idle(); #1;
    chk("R4 clear priority", 32'(stat_out), 0);
    chk("R1 tag survives clear", 32'(tag_out), 32'h0ABC);
    // R7: generic mode hit with valid clear; write-through ignored for ready
    stat_in = 3'b100; stat_we = 1; clock_in(); idle();
    user_mode = 1; is_write = 1; #1;
    chk("R7 hit without valid", 32'(hit), 1);
    chk("R7 wt ignored", 32'(rdy_n), 0);
    user_mode = 0; #1;
    chk("R6 invalid defined mode", 32'(hit), 0);
    // R8: deselected writes ignored
    sel_b = 0; tag_in = 12'h123; tag_we = 1; stat_in = 3'b111; stat_we = 1;
    clock_in(); idle(); sel_b = 1; tag_in = 12'hABC; #1;
    chk("R8 tag untouched", 32'(tag_out), 32'h0ABC);
    chk("R8 status untouched", 32'(stat_out), 32'h4);
    // R9: force overrides extra ready
    rdy_ext_n = 0; rdy_force = 1; #1;
    chk("R9 force high", 32'(rdy_n), 1);
    rdy_force = 0; #1;
    chk("R9 extra ready", 32'(rdy_n), 0);
    rdy_ext_n = 1;

    for (int v = 0; v < 4000; v++) begin
      addr = AW'($urandom_range(0, 15) * 17);
      tag_in = ($urandom_range(0, 1) != 0) ? mtag[addr] : TW'($urandom);
      stat_in = 3'($urandom);
      sel_a_n = ($urandom_range(0, 9) == 0);
      sel_b = ($urandom_range(0, 9) != 0);
      tag_we = ($urandom_range(0, 7) == 0);
      stat_we = ($urandom_range(0, 3) == 0);
      clr_n = ($urandom_range(0, 99) != 0);
      tag_oe = 1'($urandom); stat_oe = 1'($urandom); rdy_oe = 1'($urandom);
      user_mode = ($urandom_range(0, 4) == 0);
      rdy_force = ($urandom_range(0, 9) == 0);
      rdy_ext_n = ($urandom_range(0, 7) != 0);
      is_write = 1'($urandom);
      check_all();
      clock_in();
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule